// File: doc/BRIEF.md
# Block Write-Protect Lock Manager

This block holds one protection state for each erase block of a small flash array and changes those states on command. There are three states: open (writable), locked, and tight. A block in the tight state stays tight until a cold reset. Software first writes a start block address and an end block address. It then issues one of four commands: open a range, lock a range, tighten a range, or open every block. The manager visits the affected blocks one per clock. The visit order, and the point at which a walk stops early, depend on the command.

The manager reports four things. A one-hot status register shows the state most recently written. A busy flag is high while a walk runs. A one-cycle done pulse marks the end of each command, and a range-error flag comes with that pulse. All block states are also exported as a flat vector, so that program and erase gating logic elsewhere can use them. The address fields are `ADDR_W = $clog2(NUM_BLOCKS)` bits wide. When the block count is not a power of two, an address can therefore point past the last block, and the walk reports this as an error.

Top module: `wp_lock_mgr`

## Requirements
- R1: Each block state and `wp_status` are one-hot codes: tight = 3'b001, locked = 3'b010, open = 3'b100. Block i sits at `block_prot[3*i+2:3*i]`.
- R2: A cold reset (`cold_rst`) does the following: every block becomes locked, `wp_status` becomes 3'b010, both address registers become 0, and `busy`, `done` and `range_err` become 0.
- R3: A warm reset (`rst`) sets `wp_status` to 3'b010 and clears the address registers and the walk. It leaves every block state unchanged.
- R4: `start_we` loads the low `ADDR_W` bits of `addr_wdata` into both the start register and the end register. `end_we` loads only the end register, and `end_we` wins over `start_we` for the end register when both are high in the same cycle.
- R5: Open-range (`cmd_op` 0) and lock-range (`cmd_op` 1) visit the blocks from start to end inclusive, in ascending order. Each visited block and `wp_status` take the new state. The walk stops at the first tight block it meets and leaves that block unchanged.
- R6: Tighten-range (`cmd_op` 2) visits the same range. It passes over open blocks without stopping and makes every other visited block tight, updating `wp_status` to 3'b001.
- R7: Open-all (`cmd_op` 3) visits blocks from 0 up to `NUM_BLOCKS-1`, ignores the address registers, and stops at the first tight block.
- R8: A visit to an index at or above `NUM_BLOCKS` ends the walk with no change to any state, and `range_err` is high together with `done`.
- R9: `busy` is high for exactly one cycle per visited block. `done` is a one-cycle pulse in the cycle after the last visit. A range command whose start is above its end visits nothing: it raises `done` in the next cycle without `busy`.
- R10: While `busy` is high, `cmd_valid`, `start_we` and `end_we` are ignored.
- R11: Block states change only during a walk, and a tight block stays tight until a cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| cold_rst | input | 1 | Cold reset, synchronous, active high; also relocks all blocks |
| start_we | input | 1 | Write strobe for the start address (also loads end) |
| end_we | input | 1 | Write strobe for the end address |
| addr_wdata | input | DATA_W | Address write data; low ADDR_W bits are kept |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 open range, 1 lock range, 2 tighten range, 3 open all |
| start_addr | output | ADDR_W | Start address register |
| end_addr | output | ADDR_W | End address register |
| wp_status | output | 3 | Last state written, one-hot |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| range_err | output | 1 | Walk reached an index beyond the array; valid with done |
| block_prot | output | 3*NUM_BLOCKS | All block states, three bits each |

## Verification
Several properties are checked on every cycle: the one-hot coding of every block and of the status, the rule that tight is never left and that open never jumps straight to tight, the freezing of block states and addresses outside the rules, the copy of start into end, and the shape of the done and error pulses. Other behaviour can only be shown by the bench's scenarios: which blocks a walk actually changes, where it stops early, how many cycles it takes, and how errors arise past the last block. The bench sweeps every start/end pair of the 4-bit address space with rotating commands against an arithmetic model, and it also injects strobes during walks.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam logic [2:0] PS_TIGHT  = 3'b001;
  localparam logic [2:0] PS_LOCKED = 3'b010;
  localparam logic [2:0] PS_OPEN   = 3'b100;
  localparam logic [2:0] WP_STATUS_RST = PS_LOCKED;

  typedef enum logic [1:0] {
    OP_OPEN_RANGE = 2'd0,
    OP_LOCK_RANGE = 2'd1,
    OP_TIGHTEN    = 2'd2,
    OP_OPEN_ALL   = 2'd3
  } wp_op_t;
endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold_rst,
  input  logic              hold,
  input  logic              start_we,
  input  logic              end_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q
);
  logic [ADDR_W-1:0] field;
  assign field = wdata[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || cold_rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!hold) begin
      if (start_we) lo_q <= field;
      if (end_we || start_we) hi_q <= field;
    end
  end
endmodule

// File: rtl/wp_prot_array.sv
module wp_prot_array
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 4
) (
  input  logic                    clk,
  input  logic                    cold_rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_idx,
  input  logic [2:0]              wr_state,
  input  logic [ADDR_W-1:0]       rd_idx,
  output logic [2:0]              rd_state,
  output logic [3*NUM_BLOCKS-1:0] all_state
);
  localparam logic [ADDR_W:0] NB_W = (ADDR_W+1)'(NUM_BLOCKS);

  logic [2:0] arr [NUM_BLOCKS];

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      for (int i = 0; i < NUM_BLOCKS; i++) arr[i] <= PS_LOCKED;
    end else if (wr_en && ({1'b0, wr_idx} < NB_W)) begin
      arr[wr_idx] <= wr_state;
    end
  end

  always_comb begin
    rd_state = 3'b000;
    if ({1'b0, rd_idx} < NB_W) rd_state = arr[rd_idx];
  end

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_flat
    assign all_state[3*g +: 3] = arr[g];
  end
endmodule

// File: rtl/wp_walker.sv
module wp_walker
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cold_rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] range_lo,
  input  logic [ADDR_W-1:0] range_hi,
  input  logic [2:0]        cur_state,
  output logic [ADDR_W-1:0] idx,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic              wr_en,
  output logic [2:0]        wr_state
);
  localparam logic [ADDR_W:0]   NB_W     = (ADDR_W+1)'(NUM_BLOCKS);
  localparam logic [ADDR_W-1:0] LAST_BLK = ADDR_W'(NUM_BLOCKS-1);

  wp_op_t            op_q;
  logic [ADDR_W-1:0] last_q;
  logic              beyond, halt, finish, write_ok;

  always_comb begin
    unique case (op_q)
      OP_LOCK_RANGE: wr_state = PS_LOCKED;
      OP_TIGHTEN:    wr_state = PS_TIGHT;
      default:       wr_state = PS_OPEN;
    endcase
  end

  always_comb begin
    beyond   = ({1'b0, idx} >= NB_W);
    halt     = 1'b0;
    write_ok = 1'b0;
    if (beyond) begin
      halt = 1'b1;
    end else if (op_q == OP_TIGHTEN) begin
      write_ok = (cur_state != PS_OPEN);
    end else if (cur_state == PS_TIGHT) begin
      halt = 1'b1;
    end else begin
      write_ok = 1'b1;
    end
    finish = halt || (idx == last_q);
    wr_en  = busy && write_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || cold_rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      range_err <= 1'b0;
      idx       <= '0;
      last_q    <= '0;
      op_q      <= OP_OPEN_RANGE;
    end else begin
      done      <= 1'b0;
      range_err <= 1'b0;
      if (busy) begin
        if (finish) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          range_err <= beyond;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (cmd_valid) begin
        op_q <= wp_op_t'(cmd_op);
        if (wp_op_t'(cmd_op) == OP_OPEN_ALL) begin
          idx    <= '0;
          last_q <= LAST_BLK;
          busy   <= 1'b1;
        end else if (range_lo > range_hi) begin
          done <= 1'b1;
        end else begin
          idx    <= range_lo;
          last_q <= range_hi;
          busy   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cold_rst,
  input  logic                    start_we,
  input  logic                    end_we,
  input  logic [DATA_W-1:0]       addr_wdata,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  output logic [ADDR_W-1:0]       start_addr,
  output logic [ADDR_W-1:0]       end_addr,
  output logic [2:0]              wp_status,
  output logic                    busy,
  output logic                    done,
  output logic                    range_err,
  output logic [3*NUM_BLOCKS-1:0] block_prot
);
  logic [ADDR_W-1:0] walk_idx;
  logic [2:0]        cur_state, wr_state;
  logic              wr_en;

  wp_range_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .hold(busy),
    .start_we(start_we), .end_we(end_we), .wdata(addr_wdata),
    .lo_q(start_addr), .hi_q(end_addr)
  );

  wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .cold_rst(cold_rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .range_lo(start_addr), .range_hi(end_addr), .cur_state(cur_state),
    .idx(walk_idx), .busy(busy), .done(done), .range_err(range_err),
    .wr_en(wr_en), .wr_state(wr_state)
  );

  wp_prot_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .cold_rst(cold_rst),
    .wr_en(wr_en), .wr_idx(walk_idx), .wr_state(wr_state),
    .rd_idx(walk_idx), .rd_state(cur_state), .all_state(block_prot)
  );

  always_ff @(posedge clk) begin
    if (rst || cold_rst) wp_status <= WP_STATUS_RST;
    else if (wr_en)      wp_status <= wr_state;
  end
endmodule

// File: rtl/wp_lock_mgr_chk.sv
module wp_lock_mgr_chk #(
  parameter int NUM_BLOCKS = 12,
  parameter int ADDR_W     = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cold_rst,
  input logic                    start_we,
  input logic                    end_we,
  input logic [ADDR_W-1:0]       start_addr,
  input logic [ADDR_W-1:0]       end_addr,
  input logic [2:0]              wp_status,
  input logic                    busy,
  input logic                    done,
  input logic                    range_err,
  input logic [3*NUM_BLOCKS-1:0] block_prot
);
  p_status_onehot_r1: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $onehot(wp_status));

  p_start_copies_end_r4: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (!busy && start_we && !end_we) |=> (end_addr == start_addr));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst || cold_rst)
    range_err |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst || cold_rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst || cold_rst)
    done |-> !busy);

  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (rst || cold_rst)
    busy |=> ($stable(start_addr) && $stable(end_addr)));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst || cold_rst)
    !busy |=> $stable(block_prot));

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    p_block_onehot_r1: assert property (@(posedge clk) disable iff (rst || cold_rst)
      $onehot(block_prot[3*g +: 3]));
    p_tight_sticky_r11: assert property (@(posedge clk) disable iff (rst || cold_rst)
      (block_prot[3*g +: 3] == 3'b001) |=> (block_prot[3*g +: 3] == 3'b001));
    p_open_not_tight_r6: assert property (@(posedge clk) disable iff (rst || cold_rst)
      (block_prot[3*g +: 3] == 3'b100) |=> (block_prot[3*g +: 3] != 3'b001));
  end
endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cold_rst(cold_rst), .start_we(start_we), .end_we(end_we),
  .start_addr(start_addr), .end_addr(end_addr), .wp_status(wp_status),
  .busy(busy), .done(done), .range_err(range_err), .block_prot(block_prot)
);

// File: tb/wp_lock_mgr_bench.sv
module wp_lock_mgr_bench;
  localparam int NB = 12;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1, cold_rst = 1'b1;
  logic          start_we = 1'b0, end_we = 1'b0, cmd_valid = 1'b0;
  logic [DW-1:0] addr_wdata = '0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] start_addr, end_addr;
  logic [2:0]    wp_status;
  logic          busy, done, range_err;
  logic [3*NB-1:0] block_prot;

  int checks = 0, fails = 0, cycles = 0;
  logic [2:0] m [NB];
  logic [2:0] m_ws;
  int m_lo, m_hi;

  wp_lock_mgr #(.NUM_BLOCKS(NB), .DATA_W(DW)) u_wp_lock_mgr (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .start_we(start_we), .end_we(end_we),
    .addr_wdata(addr_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .start_addr(start_addr), .end_addr(end_addr), .wp_status(wp_status),
    .busy(busy), .done(done), .range_err(range_err), .block_prot(block_prot)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3*NB-1:0] model_flat();
    logic [3*NB-1:0] f;
    for (int i = 0; i < NB; i++) f[3*i +: 3] = m[i];
    return f;
  endfunction

  task automatic do_reset(bit cold);
    @(negedge clk);
    if (cold) cold_rst = 1'b1; else rst = 1'b1;
    @(negedge clk);
    cold_rst = 1'b0; rst = 1'b0;
    if (cold) for (int i = 0; i < NB; i++) m[i] = 3'b010;
    m_ws = 3'b010; m_lo = 0; m_hi = 0;
    chk(cold ? "R2 blocks" : "R3 blocks kept", 64'(block_prot), 64'(model_flat()));
    chk(cold ? "R2 status" : "R3 status", 64'(wp_status), 64'(3'b010));
    chk(cold ? "R2 addr" : "R3 addr", 64'({start_addr, end_addr}), 64'(0));
    chk(cold ? "R2 idle" : "R3 idle", 64'({busy, done, range_err}), 64'(0));
  endtask

  task automatic wr_addr(bit s, bit e, int val);
    @(negedge clk);
    start_we = s; end_we = e; addr_wdata = DW'(val);
    @(negedge clk);
    start_we = 1'b0; end_we = 1'b0;
    if (e) m_hi = val % 16; else if (s) m_hi = val % 16;
    if (s) m_lo = val % 16;
  endtask

  task automatic model(int op, output int visits, output bit err);
    int first, last;
    logic [2:0] nst;
    nst = (op == 1) ? 3'b010 : (op == 2) ? 3'b001 : 3'b100;
    first = (op == 3) ? 0 : m_lo;
    last  = (op == 3) ? NB - 1 : m_hi;
    visits = 0; err = 1'b0;
    for (int b = first; b <= last; b++) begin
      visits++;
      if (b >= NB) begin err = 1'b1; break; end
      if (op == 2) begin
        if (m[b] == 3'b100) continue;
        m[b] = 3'b001; m_ws = 3'b001;
      end else begin
        if (m[b] == 3'b001) break;
        m[b] = nst; m_ws = nst;
      end
    end
  endtask

  task automatic run_cmd(int op, bit inject);
    int visits, n;
    bit err;
    string tag;
    tag = (op == 2) ? "R6" : (op == 3) ? "R7" : "R5";
    model(op, visits, err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    for (int w = 0; w < 40; w++) begin
      if (done) break;
      if (busy) begin
        n++;
        if (inject && n == 2) begin
          cmd_valid = 1'b1; cmd_op = 2'd3; start_we = 1'b1; end_we = 1'b1;
          addr_wdata = 16'h0005;
        end
      end
      @(negedge clk);
      cmd_valid = 1'b0; start_we = 1'b0; end_we = 1'b0;
    end
    chk("R9 done seen", 64'(done), 64'(1));
    chk("R9 busy cycles", 64'(n), 64'(visits));
    chk(tag, 64'(block_prot), 64'(model_flat()));
    chk({tag, " status"}, 64'(wp_status), 64'(m_ws));
    chk("R8 range_err", 64'(range_err), 64'(err));
    if (inject)
      chk("R10 addr kept", 64'({start_addr, end_addr}), 64'({4'(m_lo), 4'(m_hi)}));
    @(negedge clk);
    chk("R9 done pulse", 64'({done, busy}), 64'(0));
  endtask

  initial begin
    for (int i = 0; i < NB; i++) m[i] = 3'b010;
    m_ws = 3'b010;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    do_reset(1'b1);

    wr_addr(1, 0, 16'h1237);
    chk("R4 start", 64'(start_addr), 64'(7));
    chk("R4 end copy", 64'(end_addr), 64'(7));
    wr_addr(0, 1, 16'hff0a);
    chk("R4 end only", 64'({start_addr, end_addr}), 64'({4'd7, 4'd10}));
    wr_addr(1, 1, 16'h0003);
    chk("R4 both", 64'({start_addr, end_addr}), 64'({4'd3, 4'd3}));

    wr_addr(1, 0, 2); wr_addr(0, 1, 9);
    run_cmd(0, 0);
    wr_addr(1, 0, 4); wr_addr(0, 1, 6);
    run_cmd(2, 0);
    wr_addr(1, 0, 0); wr_addr(0, 1, 11);
    run_cmd(2, 0);
    run_cmd(3, 0);
    wr_addr(1, 0, 0); wr_addr(0, 1, 15);
    run_cmd(1, 1);
    wr_addr(1, 0, 8); wr_addr(0, 1, 3);
    run_cmd(0, 0);

    do_reset(1'b0);
    do_reset(1'b1);
    wr_addr(1, 0, 10); wr_addr(0, 1, 14);
    run_cmd(0, 0);
    chk("R8 blocks 10-11 open", 64'(block_prot[35:30]), 64'(6'b100100));

    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        if (((s * 16 + e) % 41) == 40) do_reset(1'b1);
        wr_addr(1, 0, s);
        chk("R4 sweep copy", 64'(end_addr), 64'(s));
        wr_addr(0, 1, e);
        run_cmd((s * 3 + e + (s >> 2)) % 4, (e % 7) == 3);
      end
    end
    finish_run();
  end
endmodule